// File: doc/BRIEF.md
# Listen-Time Profiling Counters

This block keeps four free-running event counters for a radio front end: every clock cycle, cycles flagged busy because the receive channel is not clear, transmit cycles and receive cycles. Each activity source is a single-cycle input strobe. When the block gets a sample request, it freezes all four counters together, copies them into snapshot registers, clears them and then lets them run again. Every snapshot therefore describes exactly the same interval, and no activity is lost.

From a snapshot the block works out an approximate idle ("listen") time in milliseconds: cycles minus receive minus transmit, divided by a fixed number of cycles per millisecond. It also works out the share of cycles, in whole percent, spent on transmit, receive and busy. All four divisions go one after another through a single serial divider. A one-cycle valid strobe marks the point where every result is in place. Each listen result is added to a running per-period total. A period-restart input moves that total into a last-value register and starts the total again from zero.

Top module: `listen_profiler`

## Requirements
- R1: After reset, every snapshot, result, total and last-value output reads 0, and the valid strobe is low.
- R2: Each counter counts its strobe on every rising edge; the cycle counter counts every rising edge after reset. A snapshot holds the counts from the edge after the previous accepted request up to and including the edge at which the new request is sampled.
- R3: A strobe that arrives while the counters are frozen is held and added after counting resumes. It shows up in the following snapshot, and none is lost.
- R4: The listen output equals floor((cycles - rx - tx) / MS_CYCLES) of the snapshot.
- R5: When the snapshot cycle count is 0, or when rx + tx exceeds cycles, the listen output is 0.
- R6: The tx, rx and busy percentage outputs equal floor(value * 100 / cycles) of the snapshot, or 0 when cycles is 0. Each lies in 0..100.
- R7: The valid strobe is high for exactly one cycle per accepted request. While it is high, all snapshot and result outputs already hold the new values.
- R8: In the cycle of each valid strobe, the listen total increases by the new listen value.
- R9: A period-restart pulse copies the listen total into the last-value output and sets the total to 0 one cycle later. If it falls in the same cycle as a valid strobe, the new listen value becomes the new total.
- R10: A sample request that arrives while a previous sample is still being processed has no effect. The events it would have closed off are counted in the next snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busyEv | input | 1 | Receive-channel-busy strobe |
| txEv | input | 1 | Transmit-activity strobe |
| rxEv | input | 1 | Receive-activity strobe |
| sampleReq | input | 1 | Start freeze/snapshot/clear/unfreeze |
| periodRestart | input | 1 | Move listen total to last-value, clear total |
| snapCycles | output | CNT_W | Snapshot of total cycles |
| snapBusy | output | CNT_W | Snapshot of busy cycles |
| snapTx | output | CNT_W | Snapshot of transmit cycles |
| snapRx | output | CNT_W | Snapshot of receive cycles |
| listenMs | output | CNT_W | Listen time in milliseconds |
| listenValid | output | 1 | One-cycle strobe, all results updated |
| listenTotal | output | TOT_W | Running per-period listen total |
| lastListenTotal | output | TOT_W | Total captured at the last restart |
| txPct | output | 7 | Transmit percentage of cycles |
| rxPct | output | 7 | Receive percentage of cycles |
| busyPct | output | 7 | Busy percentage of cycles |

## Verification
Activity strobes run without pause, including through the freeze window. A design that dropped the held strobes, or counted them twice, would give snapshots that no longer add up to the bench's per-edge tally. Activity patterns range from no events at all to every strobe on every cycle. The all-on pattern drives rx + tx above cycles, so a design that forgot the clamp would wrap to a huge listen value. A request is sent in the middle of a division: a design that accepted it would cut the interval short and corrupt the next snapshot. Period restarts are placed between samples so that the running and last-value totals can be compared against the bench's own sum.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int NSRC     = 4;
  localparam int SRC_CYC  = 0;
  localparam int SRC_BUSY = 1;
  localparam int SRC_TX   = 2;
  localparam int SRC_RX   = 3;
  localparam int PCT_W    = 7;

  typedef enum logic [1:0] {
    OP_LISTEN = 2'd0,
    OP_TX     = 2'd1,
    OP_RX     = 2'd2,
    OP_BUSY   = 2'd3
  } opSel_t;

  typedef struct packed {
    logic   freeze;
    logic   capture;
    logic   clear;
    logic   divStart;
    logic   loadRes;
    logic   finish;
    opSel_t opSel;
  } ctlStrobe_t;
endpackage

// File: rtl/lp_event_counter.sv
module lp_event_counter #(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev,
  input  logic             freeze,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [PEND_W-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= '0;
    end else if (freeze) begin
      pend <= pend + PEND_W'(ev);
      if (clear) cnt <= '0;
    end else begin
      cnt  <= cnt + CNT_W'(ev) + CNT_W'(pend);
      pend <= '0;
    end
  end

  // R3
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !clear) |=> $stable(cnt));
  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));
  // R3
  pend_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> (pend != PEND_MAX));
endmodule

// File: rtl/lp_serial_divider.sv
module lp_serial_divider #(
  parameter int NUM_W = 39,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic [NUM_W-1:0] quo,
  output logic             done
);
  localparam int STEP_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0]  remR;
  logic [DEN_W-1:0]  denR;
  logic [STEP_W-1:0] stepCnt;
  logic              busy;
  logic [DEN_W:0]    shifted;
  logic              fits;

  assign shifted = {remR, quo[NUM_W-1]};
  assign fits    = shifted >= {1'b0, denR};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo     <= '0;
      remR    <= '0;
      denR    <= '0;
      stepCnt <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else if (start) begin
      quo     <= numer;
      remR    <= '0;
      denR    <= denom;
      stepCnt <= STEP_W'(NUM_W);
      busy    <= 1'b1;
      done    <= 1'b0;
    end else if (busy) begin
      quo  <= {quo[NUM_W-2:0], fits};
      remR <= fits ? (shifted[DEN_W-1:0] - denR) : shifted[DEN_W-1:0];
      stepCnt <= stepCnt - 1'b1;
      if (stepCnt == STEP_W'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  // R4
  div_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  // R7
  div_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/lp_control.sv
module lp_control
  import lp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sampleReq,
  input  logic       zeroCase,
  input  logic       divDone,
  output ctlStrobe_t ctl
);
  typedef enum logic [2:0] {
    sIdle, sFreeze, sCapture, sClear, sIssue, sWait, sFinish
  } state_t;

  state_t state, nextState;
  opSel_t opR, nextOp;

  always_comb begin
    ctl       = '0;
    ctl.opSel = opR;
    nextState = state;
    nextOp    = opR;
    ctl.freeze = (state == sFreeze) || (state == sCapture) || (state == sClear);
    unique case (state)
      sIdle:    if (sampleReq) nextState = sFreeze;
      sFreeze:  nextState = sCapture;
      sCapture: begin
        ctl.capture = 1'b1;
        nextState   = sClear;
      end
      sClear: begin
        ctl.clear = 1'b1;
        nextOp    = OP_LISTEN;
        nextState = sIssue;
      end
      sIssue, sWait: begin
        if ((state == sIssue && zeroCase) || (state == sWait && divDone)) begin
          ctl.loadRes = 1'b1;
          if (opR == OP_BUSY) nextState = sFinish;
          else begin
            nextOp    = opSel_t'(opR + 2'd1);
            nextState = sIssue;
          end
        end else if (state == sIssue) begin
          ctl.divStart = 1'b1;
          nextState    = sWait;
        end
      end
      sFinish: begin
        ctl.finish = 1'b1;
        nextState  = sIdle;
      end
      default: nextState = sIdle;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= sIdle;
      opR   <= OP_LISTEN;
    end else begin
      state <= nextState;
      opR   <= nextOp;
    end
  end

  // R10
  busy_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != sIdle) |=> (state != sFreeze));
endmodule

// File: rtl/lp_datapath.sv
module lp_datapath
  import lp_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int TOT_W     = 32,
  parameter int MS_CYCLES = 44000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busyEv,
  input  logic             txEv,
  input  logic             rxEv,
  input  logic             periodRestart,
  input  ctlStrobe_t       ctl,
  output logic             zeroCase,
  output logic             divDone,
  output logic [CNT_W-1:0] snapCycles,
  output logic [CNT_W-1:0] snapBusy,
  output logic [CNT_W-1:0] snapTx,
  output logic [CNT_W-1:0] snapRx,
  output logic [CNT_W-1:0] listenMs,
  output logic             listenValid,
  output logic [TOT_W-1:0] listenTotal,
  output logic [TOT_W-1:0] lastListenTotal,
  output logic [PCT_W-1:0] txPct,
  output logic [PCT_W-1:0] rxPct,
  output logic [PCT_W-1:0] busyPct
);
  localparam int NUM_W = CNT_W + 7;
  localparam int DEN_W = CNT_W;

  logic [NSRC-1:0]  evVec;
  logic [CNT_W-1:0] live [NSRC];
  logic [CNT_W-1:0] snap [NSRC];

  assign evVec = {rxEv, txEv, busyEv, 1'b1};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    lp_event_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (evVec[g]),
      .freeze(ctl.freeze),
      .clear (ctl.clear),
      .cnt   (live[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          snap[g] <= '0;
      else if (ctl.capture) snap[g] <= live[g];
    end
  end

  logic signed [CNT_W+1:0] idleDiff;
  logic [CNT_W-1:0]        pctSrc;
  logic [NUM_W-1:0]        numer;
  logic [DEN_W-1:0]        denom;
  logic [NUM_W-1:0]        quo;
  logic [NUM_W-1:0]        resVal;

  assign idleDiff = $signed({2'b00, snap[SRC_CYC]}) - $signed({2'b00, snap[SRC_RX]})
                  - $signed({2'b00, snap[SRC_TX]});

  always_comb begin
    unique case (ctl.opSel)
      OP_TX:   pctSrc = snap[SRC_TX];
      OP_RX:   pctSrc = snap[SRC_RX];
      default: pctSrc = snap[SRC_BUSY];
    endcase
    if (ctl.opSel == OP_LISTEN) begin
      numer    = NUM_W'(idleDiff[CNT_W-1:0]);
      denom    = DEN_W'(MS_CYCLES);
      zeroCase = (snap[SRC_CYC] == '0) || idleDiff[CNT_W+1];
    end else begin
      numer    = NUM_W'(pctSrc) * NUM_W'(100);
      denom    = snap[SRC_CYC];
      zeroCase = (snap[SRC_CYC] == '0);
    end
  end

  lp_serial_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) i_div (
    .clk  (clk),
    .rst_n(rst_n),
    .start(ctl.divStart),
    .numer(numer),
    .denom(denom),
    .quo  (quo),
    .done (divDone)
  );

  assign resVal = zeroCase ? '0 : quo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      listenMs        <= '0;
      txPct           <= '0;
      rxPct           <= '0;
      busyPct         <= '0;
      listenValid     <= 1'b0;
      listenTotal     <= '0;
      lastListenTotal <= '0;
    end else begin
      listenValid <= ctl.finish;
      if (ctl.loadRes) begin
        unique case (ctl.opSel)
          OP_LISTEN: listenMs <= resVal[CNT_W-1:0];
          OP_TX:     txPct    <= resVal[PCT_W-1:0];
          OP_RX:     rxPct    <= resVal[PCT_W-1:0];
          default:   busyPct  <= resVal[PCT_W-1:0];
        endcase
      end
      if (periodRestart) begin
        lastListenTotal <= listenTotal;
        listenTotal     <= ctl.finish ? TOT_W'(listenMs) : '0;
      end else if (ctl.finish) begin
        listenTotal <= listenTotal + TOT_W'(listenMs);
      end
    end
  end

  assign snapCycles = snap[SRC_CYC];
  assign snapBusy   = snap[SRC_BUSY];
  assign snapTx     = snap[SRC_TX];
  assign snapRx     = snap[SRC_RX];

  // R5
  clamp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.loadRes && ctl.opSel == OP_LISTEN && zeroCase) |=> (listenMs == '0));
  // R6
  pct_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txPct <= PCT_W'(100)) && (rxPct <= PCT_W'(100)) && (busyPct <= PCT_W'(100)));
  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    listenValid |=> !listenValid);
  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (periodRestart && !ctl.finish) |=> (listenTotal == '0));
endmodule

// File: rtl/listen_profiler.sv
module listen_profiler
  import lp_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int TOT_W     = 32,
  parameter int MS_CYCLES = 44000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busyEv,
  input  logic             txEv,
  input  logic             rxEv,
  input  logic             sampleReq,
  input  logic             periodRestart,
  output logic [CNT_W-1:0] snapCycles,
  output logic [CNT_W-1:0] snapBusy,
  output logic [CNT_W-1:0] snapTx,
  output logic [CNT_W-1:0] snapRx,
  output logic [CNT_W-1:0] listenMs,
  output logic             listenValid,
  output logic [TOT_W-1:0] listenTotal,
  output logic [TOT_W-1:0] lastListenTotal,
  output logic [6:0]       txPct,
  output logic [6:0]       rxPct,
  output logic [6:0]       busyPct
);
  ctlStrobe_t ctl;
  logic       zeroCase;
  logic       divDone;

  lp_control i_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sampleReq(sampleReq),
    .zeroCase (zeroCase),
    .divDone  (divDone),
    .ctl      (ctl)
  );

  lp_datapath #(.CNT_W(CNT_W), .TOT_W(TOT_W), .MS_CYCLES(MS_CYCLES)) i_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .busyEv         (busyEv),
    .txEv           (txEv),
    .rxEv           (rxEv),
    .periodRestart  (periodRestart),
    .ctl            (ctl),
    .zeroCase       (zeroCase),
    .divDone        (divDone),
    .snapCycles     (snapCycles),
    .snapBusy       (snapBusy),
    .snapTx         (snapTx),
    .snapRx         (snapRx),
    .listenMs       (listenMs),
    .listenValid    (listenValid),
    .listenTotal    (listenTotal),
    .lastListenTotal(lastListenTotal),
    .txPct          (txPct),
    .rxPct          (rxPct),
    .busyPct        (busyPct)
  );
endmodule

// File: tb/test_listen_profiler.sv
`timescale 1ns/1ps
module test_listen_profiler;
  localparam int CNT_W = 32;
  localparam int TOT_W = 32;
  localparam int MS    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busyEv = 1'b0, txEv = 1'b0, rxEv = 1'b0;
  logic sampleReq = 1'b0, periodRestart = 1'b0;
  logic [CNT_W-1:0] snapCycles, snapBusy, snapTx, snapRx, listenMs;
  logic listenValid;
  logic [TOT_W-1:0] listenTotal, lastListenTotal;
  logic [6:0] txPct, rxPct, busyPct;

  always #2.5 clk = ~clk;

  listen_profiler #(.CNT_W(CNT_W), .TOT_W(TOT_W), .MS_CYCLES(MS)) i_listen_profiler (
    .clk(clk), .rst_n(rst_n), .busyEv(busyEv), .txEv(txEv), .rxEv(rxEv),
    .sampleReq(sampleReq), .periodRestart(periodRestart),
    .snapCycles(snapCycles), .snapBusy(snapBusy), .snapTx(snapTx), .snapRx(snapRx),
    .listenMs(listenMs), .listenValid(listenValid), .listenTotal(listenTotal),
    .lastListenTotal(lastListenTotal), .txPct(txPct), .rxPct(rxPct), .busyPct(busyPct)
  );

  int total = 0;
  int bad = 0;

  // activity generator
  int genCyc = 0;
  int modeT = 2, modeR = 3, modeB = 2;
  bit allOn = 1'b0, allOff = 1'b1;
  always @(negedge clk) begin
    genCyc++;
    txEv   <= !allOff && (allOn || (genCyc % modeT == 0));
    rxEv   <= !allOff && (allOn || (genCyc % modeR == 1));
    busyEv <= !allOff && (allOn || (genCyc % modeB != 0));
  end

  // per-edge reference tally
  longint accC = 0, accB = 0, accT = 0, accR = 0;
  longint expC = 0, expB = 0, expT = 0, expR = 0;
  bit realReq = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) begin
      accC = 0; accB = 0; accT = 0; accR = 0;
    end else begin
      accC++;
      accB += longint'(busyEv);
      accT += longint'(txEv);
      accR += longint'(rxEv);
      if (sampleReq && realReq) begin
        expC = accC; expB = accB; expT = accT; expR = accR;
        accC = 0; accB = 0; accT = 0; accR = 0;
      end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", wd);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic request(bit real_);
    @(negedge clk);
    sampleReq = 1'b1;
    realReq   = real_;
    @(negedge clk);
    sampleReq = 1'b0;
    realReq   = 1'b0;
  endtask

  task automatic waitValid();
    int n = 0;
    while (!listenValid && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(listenValid, "R7 valid seen", longint'(listenValid), 1);
  endtask

  longint expTot = 0;

  task automatic checkResults();
    longint diff, expL, eTx, eRx, eBusy;
    diff = expC - expR - expT;
    expL = (expC == 0 || diff < 0) ? 0 : diff / MS;
    eTx   = (expC == 0) ? 0 : expT * 100 / expC;
    eRx   = (expC == 0) ? 0 : expR * 100 / expC;
    eBusy = (expC == 0) ? 0 : expB * 100 / expC;
    expTot += expL;
    chk(snapCycles == CNT_W'(expC), "R2 R3 cycles", longint'(snapCycles), expC);
    chk(snapBusy == CNT_W'(expB), "R2 R3 busy", longint'(snapBusy), expB);
    chk(snapTx == CNT_W'(expT), "R2 R3 tx", longint'(snapTx), expT);
    chk(snapRx == CNT_W'(expR), "R2 R3 rx", longint'(snapRx), expR);
    chk(longint'(listenMs) == expL, (diff < 0) ? "R5 listen clamp" : "R4 listen",
        longint'(listenMs), expL);
    chk(longint'(txPct) == eTx, "R6 txPct", longint'(txPct), eTx);
    chk(longint'(rxPct) == eRx, "R6 rxPct", longint'(rxPct), eRx);
    chk(longint'(busyPct) == eBusy, "R6 busyPct", longint'(busyPct), eBusy);
    chk(longint'(listenTotal) == expTot, "R8 total", longint'(listenTotal), expTot);
    @(negedge clk);
    chk(!listenValid, "R7 single pulse", longint'(listenValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!listenValid && snapCycles == 0 && snapBusy == 0 && snapTx == 0 && snapRx == 0,
        "R1 reset snaps", longint'(snapCycles), 0);
    chk(listenMs == 0 && listenTotal == 0 && lastListenTotal == 0 &&
        txPct == 0 && rxPct == 0 && busyPct == 0, "R1 reset results",
        longint'(listenMs), 0);
    rst_n = 1'b1;

    for (int t = 0; t < 12; t++) begin
      allOff = (t == 0);
      allOn  = (t == 11);
      modeT  = t % 4 + 2;
      modeR  = t % 3 + 3;
      modeB  = t % 5 + 1;
      repeat (20 + t * 23) @(negedge clk);
      request(1'b1);
      if (t == 5) begin
        // R10: request during processing is ignored
        repeat (30) @(negedge clk);
        request(1'b0);
      end
      waitValid();
      checkResults();
      if (t == 3 || t == 8) begin
        // R9 period restart
        @(negedge clk);
        periodRestart = 1'b1;
        @(negedge clk);
        periodRestart = 1'b0;
        chk(longint'(lastListenTotal) == expTot, "R9 last total",
            longint'(lastListenTotal), expTot);
        chk(listenTotal == 0, "R9 total cleared", longint'(listenTotal), 0);
        expTot = 0;
      end
    end
    summary();
    $finish;
  end
endmodule